// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder, K=7 Rate 1/2

This block recovers a bit stream that was protected by a rate-1/2 convolutional code with seven taps (generator masks 133 and 171 octal), which gives 64 trellis states. Each cycle in which `valid_i` is high it takes one pair of hard received bits. It scores every trellis branch by Hamming distance and keeps one surviving path into each state. It records one decision bit per state in a fixed-depth survivor store.

Once 36 decision columns belong to the current frame, every new symbol causes a traceback. The traceback starts from the state with the smallest path metric, walks all 36 stored columns from newest to oldest, and emits the oldest input bit it reaches. A frame begins with `start_i` asserted together with the first symbol of the frame. The decoder then assumes that the encoder started in state 0. Path metrics are renormalized every step, so they stay small for streams of any length.

Top module: `hd_viterbi_dec`

## Requirements
- R1: Encoder convention. The encoder state s is 6 bits, with s[5] the newest past input. For an input b the window is w={b,s}. The decoder expects sym_i[1]=parity(w & 7'b1011011) and sym_i[0]=parity(w & 7'b1111001), and the next state is {b,s[5:1]}. An error-free frame decodes to exactly its input bits, in order.
- R2: Branch metrics are Hamming distances between the received pair and each branch label. An isolated flipped bit (at most one in every 25 pairs) is corrected.
- R3: A symbol taken with start_i high starts a new frame. Before that symbol is processed, state 0 gets metric 0 and every other state gets metric 64, and the frame fill count restarts at one.
- R4: The first 36 symbols of a frame produce no output. The symbol that makes the frame length 36+k produces input bit k of the frame on bit_o. It appears two clock edges after that symbol is captured, with bit_valid_o high for one cycle.
- R5: While valid_i is low, the metrics, the survivor store and the fill count do not change. start_i without valid_i is ignored.
- R6: After each step the path metrics are reduced by the previous minimum, so the smallest metric never exceeds 2. A stream of 3000 symbols decodes correctly.
- R7: After reset, bit_valid_o and bit_o are 0 and the metrics are in the frame-start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Received pair on sym_i is valid this cycle |
| start_i | input | 1 | With valid_i: this symbol is the first of a frame |
| sym_i | input | 2 | Received hard bits, [1] for mask 133, [0] for mask 171 |
| bit_o | output | 1 | Decoded bit |
| bit_valid_o | output | 1 | bit_o holds a new decoded bit this cycle |

## Verification
The assertions assume that valid_i, start_i and sym_i change only away from the rising edge and never carry X after reset. They also assume that reset is applied before the first symbol. The metric bound relies on each step's branch metric being at most 2, which holds for any input pair. The bench drives all inputs on the falling edge. It produces symbols through its own model of the encoder, and it confines injected errors to isolated single-bit flips, except in one throwaway frame that only disturbs the metrics before a new frame starts.

// File: rtl/hdv_pkg.sv
package hdv_pkg;
  localparam int CODE_K = 7;
  localparam int ST_W   = CODE_K - 1;
  localparam int NUM_ST = 1 << ST_W;
  localparam logic [CODE_K-1:0] MASK_A = 7'o133;
  localparam logic [CODE_K-1:0] MASK_B = 7'o171;

  typedef logic [ST_W-1:0] state_t;

  // branch label for input b leaving state s; w[6] is newest
  function automatic logic [1:0] code_pair(input logic b, input state_t s);
    logic [CODE_K-1:0] w;
    w = {b, s};
    return {^(w & MASK_A), ^(w & MASK_B)};
  endfunction
endpackage

// File: rtl/hdv_acs.sv
module hdv_acs
  import hdv_pkg::*;
#(
  parameter int PM_W    = 8,
  parameter int INIT_PM = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         start_i,
  input  logic [1:0]                   sym_i,
  input  logic [PM_W-1:0]              min_i,
  output logic [NUM_ST-1:0][PM_W-1:0]  pm_o,
  output logic [NUM_ST-1:0]            dec_o
);
  localparam int HALF = NUM_ST / 2;
  localparam logic [PM_W:0] PM_MAX = {1'b0, {PM_W{1'b1}}};

  logic [NUM_ST-1:0][PM_W-1:0] pm_q, src_pm, nxt_pm;
  logic [PM_W-1:0] base;

  always_comb begin
    for (int n = 0; n < NUM_ST; n++)
      src_pm[n] = start_i ? ((n == 0) ? '0 : PM_W'(INIT_PM)) : pm_q[n];
    base = start_i ? '0 : min_i;
  end

  state_t        p0;
  logic          nb;
  logic [1:0]    lab0, lab1, bm0, bm1;
  logic [PM_W:0] c0, c1, win, diff;

  always_comb begin
    p0 = '0; nb = 1'b0; lab0 = '0; lab1 = '0; bm0 = '0; bm1 = '0;
    c0 = '0; c1 = '0; win = '0; diff = '0;
    for (int n = 0; n < NUM_ST; n++) begin
      p0   = state_t'(n << 1);
      nb   = (n >= HALF);
      lab0 = code_pair(nb, p0);
      lab1 = code_pair(nb, p0 | state_t'(1));
      bm0  = {1'b0, lab0[1] ^ sym_i[1]} + {1'b0, lab0[0] ^ sym_i[0]};
      bm1  = {1'b0, lab1[1] ^ sym_i[1]} + {1'b0, lab1[0] ^ sym_i[0]};
      c0   = {1'b0, src_pm[p0]} + (PM_W+1)'(bm0);
      c1   = {1'b0, src_pm[p0 | state_t'(1)]} + (PM_W+1)'(bm1);
      // tie keeps the even (lower) predecessor
      dec_o[n] = (c1 < c0);
      win  = (c1 < c0) ? c1 : c0;
      diff = win - {1'b0, base};
      nxt_pm[n] = (diff > PM_MAX) ? PM_MAX[PM_W-1:0] : diff[PM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_ST; n++)
        pm_q[n] <= (n == 0) ? '0 : PM_W'(INIT_PM);
    end else if (valid_i) begin
      pm_q <= nxt_pm;
    end
  end

  assign pm_o = pm_q;

  a_r5_hold_metrics: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pm_q))
    else $error("R5: metrics moved without valid_i");
endmodule

// File: rtl/hdv_best.sv
module hdv_best
  import hdv_pkg::*;
#(
  parameter int PM_W = 8
) (
  input  logic [NUM_ST-1:0][PM_W-1:0] pm_i,
  output state_t                      best_o,
  output logic [PM_W-1:0]             min_o
);
  // linear scan, strict compare keeps the lowest index on ties
  always_comb begin
    best_o = '0;
    min_o  = pm_i[0];
    for (int i = 1; i < NUM_ST; i++) begin
      if (pm_i[i] < min_o) begin
        min_o  = pm_i[i];
        best_o = state_t'(i);
      end
    end
  end
endmodule

// File: rtl/hdv_trace.sv
module hdv_trace
  import hdv_pkg::*;
#(
  parameter int TB_LEN = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [NUM_ST-1:0] dec_i,
  input  state_t            from_i,
  output logic              bit_o
);
  logic [NUM_ST-1:0] sv_q [TB_LEN];

  for (genvar g = 0; g < TB_LEN; g++) begin : g_col
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      sv_q[0] <= '0;
        else if (push_i)  sv_q[0] <= dec_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      sv_q[g] <= '0;
        else if (push_i)  sv_q[g] <= sv_q[g-1];
    end
  end

  state_t walk;
  always_comb begin
    walk = from_i;
    for (int i = 0; i < TB_LEN; i++)
      walk = {walk[ST_W-2:0], sv_q[i][walk]};
    bit_o = walk[ST_W-1];
  end
endmodule

// File: rtl/hd_viterbi_dec.sv
module hd_viterbi_dec
  import hdv_pkg::*;
#(
  parameter int PM_W    = 8,
  parameter int INIT_PM = 64,
  parameter int TB_LEN  = 36
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       start_i,
  input  logic [1:0] sym_i,
  output logic       bit_o,
  output logic       bit_valid_o
);
  localparam int CNT_W = $clog2(TB_LEN + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TB_LEN + 1);

  logic [NUM_ST-1:0][PM_W-1:0] pm;
  logic [NUM_ST-1:0]           dec;
  logic [PM_W-1:0]             min_val;
  state_t                      best;
  logic                        tb_bit, valid_q;
  logic [CNT_W-1:0]            cnt_q;

  hdv_best #(.PM_W(PM_W)) u_best (
    .pm_i(pm), .best_o(best), .min_o(min_val)
  );

  hdv_acs #(.PM_W(PM_W), .INIT_PM(INIT_PM)) u_acs (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .sym_i(sym_i), .min_i(min_val), .pm_o(pm), .dec_o(dec)
  );

  hdv_trace #(.TB_LEN(TB_LEN)) u_trace (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(valid_i), .dec_i(dec),
    .from_i(best), .bit_o(tb_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        if (start_i)           cnt_q <= CNT_W'(1);
        else if (cnt_q < FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= valid_q && (cnt_q == FULL);
      if (valid_q && (cnt_q == FULL)) bit_o <= tb_bit;
    end
  end

  a_r4_out_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(valid_i, 2))
    else $error("R4: output without a symbol two edges earlier");

  a_r3_start_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i) |=> (cnt_q == CNT_W'(1)))
    else $error("R3: frame start did not restart fill count");

  a_r5_start_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q))
    else $error("R5: fill count moved without valid_i");

  a_r6_min_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_val <= PM_W'(2))
    else $error("R6: minimum metric not renormalized");
endmodule

// File: tb/hd_viterbi_dec_bench.sv
module hd_viterbi_dec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TB = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, start = 1'b0;
  logic [1:0] sym = '0;
  logic bit_o, bit_valid_o;

  hd_viterbi_dec u_hd_viterbi_dec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .start_i(start),
    .sym_i(sym), .bit_o(bit_o), .bit_valid_o(bit_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [5:0]  enc_s = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic u_arr [4096];
  logic got_bits [4096];
  int got_n = 0;

  always @(negedge clk)
    if (rst_n && bit_valid_o && got_n < 4096) begin
      got_bits[got_n] = bit_o;
      got_n++;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] enc_pair(input logic b, input logic [5:0] s);
    logic [6:0] w;
    w = {b, s};
    return {^(w & 7'b1011011), ^(w & 7'b1111001)};
  endfunction

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic send(input logic b, input logic st, input logic [1:0] flip);
    sym   = enc_pair(b, enc_s) ^ flip;
    valid = 1'b1;
    start = st;
    enc_s = {b, enc_s[5:1]};
    @(negedge clk);
    valid = 1'b0;
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input string req, input int n, input int err_per,
                           input int gap_per, input bit start_alone);
    int mism;
    int first;
    logic b;
    logic [1:0] flip;
    got_n = 0;
    enc_s = '0;
    for (int i = 0; i < n; i++) begin
      b = next_bit();
      u_arr[i] = b;
      flip = 2'b00;
      if (err_per > 0 && (i % err_per) == err_per/2)
        flip = ((i / err_per) % 2 == 0) ? 2'b10 : 2'b01;
      send(b, i == 0, flip);
      if (gap_per > 0 && (i % gap_per) == gap_per - 1) begin
        start = start_alone;
        idle(3);
        start = 1'b0;
      end
    end
    idle(4);
    check(got_n == n - TB, {req, " output count"}, got_n, n - TB);
    mism = 0;
    first = -1;
    for (int k = 0; k < got_n; k++)
      if (got_bits[k] !== u_arr[k]) begin
        mism++;
        if (first < 0) first = k;
      end
    if (mism != 0) $display("  first wrong bit index %0d", first);
    check(mism == 0, {req, " decoded bits"}, mism, 0);
  endtask

  task automatic t_reset();
    check(bit_valid_o === 1'b0, "R7 bit_valid_o after reset", int'(bit_valid_o), 0);
    check(bit_o === 1'b0, "R7 bit_o after reset", int'(bit_o), 0);
  endtask

  task automatic t_latency();
    logic b;
    got_n = 0;
    enc_s = '0;
    for (int i = 0; i < TB; i++) begin
      b = next_bit();
      u_arr[i] = b;
      send(b, i == 0, 2'b00);
    end
    idle(3);
    check(got_n == 0, "R4 no output within first 36 symbols", got_n, 0);
    send(next_bit(), 1'b0, 2'b00);
    check(bit_valid_o === 1'b0, "R4 not yet valid one edge after", int'(bit_valid_o), 0);
    @(negedge clk);
    check(bit_valid_o === 1'b1, "R4 valid two edges after", int'(bit_valid_o), 1);
    check(bit_o === u_arr[0], "R4 first decoded bit", int'(bit_o), int'(u_arr[0]));
    @(negedge clk);
    check(bit_valid_o === 1'b0, "R4 valid is one cycle", int'(bit_valid_o), 0);
  endtask

  task automatic t_restart();
    // throwaway frame with random flips disturbs the metrics
    enc_s = '0;
    for (int i = 0; i < 60; i++) begin
      void'(next_bit());
      send(lfsr[3], i == 0, lfsr[5:4]);
    end
    idle(4);
    run_frame("R3", 120, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    run_frame("R1", 200, 0, 0, 1'b0);
    run_frame("R2", 400, 25, 0, 1'b0);
    t_latency();
    idle(4);
    run_frame("R5 gaps", 150, 0, 7, 1'b0);
    run_frame("R5 start alone", 150, 0, 11, 1'b1);
    t_restart();
    run_frame("R6", 3000, 0, 0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule